// File: doc/BRIEF.md
# IQ Serial Output Framer

This block takes one processed I/Q sample pair at a time and sends it out on a single serial data wire. It generates the serial bit clock and a frame marker itself. Each sample goes out as a 16-bit word: the 15-bit two's-complement sample first, most significant bit first, and then a flag bit that marks the word as I or Q. In every pair the I word goes before the Q word. The serial bit clock runs at half or a quarter of the master clock, set by a rate input. The rate value is captured at the moment the stream wakes.

The stream starts when the receive-active input goes high. A lead bit period comes first, with the frame marker high. After that, I and Q words follow each other for as long as receive-active stays high. When receive-active goes low, the pair already under way is completed and the block then returns to sleep, with its serial outputs held low. A one-pair holding buffer lets the source deliver the next pair while the current one is still being shifted out. A pair that arrives while the buffer is already full is dropped and raises a sticky overrun flag. A separate enable output, driven from a release input, tells the pad ring whether to drive the serial pins.

Top module: `iq_serial_framer`

## Requirements
- R1: Each word holds 16 bits. The first 15 are the sample, most significant bit first. The last bit is a flag: 1 in an I word, 0 in a Q word.
- R2: In every pair the I word is sent first and the Q word second. A stream always opens with an I word.
- R3: With `rate_fast`=1 the serial clock period is 2 master clocks, so one word takes 32 master clocks. With `rate_fast`=0 the period is 4 master clocks, so one word takes 64 master clocks. `ser_clk` is high in the first half of each period.
- R4: The rate is captured on the master clock edge that wakes the block. A change of `rate_fast` during streaming has no effect until the next wake.
- R5: `ser_data` and `ser_frame` change only together with a rising edge of `ser_clk`, so they are stable when `ser_clk` falls.
- R6: On wake there is one lead bit period with `ser_frame`=1 and `ser_data`=0 before the first I bit. After that, `ser_frame` is 1 only during the flag bit of each word.
- R7: `rx_active` is checked only at the end of each Q word. If it is 0 there, the block goes to sleep. A pair that has started is therefore always completed.
- R8: While asleep, `ser_clk`, `ser_frame` and `ser_data` are all 0.
- R9: `ser_oe` is the inverse of `out_release` in every cycle. The serial stream keeps its timing whatever value `out_release` has.
- R10: One pending pair is accepted whenever the buffer is empty, including during sleep. It is moved to the shifter at the start of each pair, which is either the end of the lead bit or the end of a Q word while still active.
- R11: If no pair is pending at the start of a pair, zero samples are sent, with their flag bits still set as in R1.
- R12: A `pair_valid` that arrives while the buffer is full, and is not consumed in that same cycle, is dropped. It sets `overrun`, which stays set until reset.
- R13: After reset the serial outputs are 0, `overrun` is 0 and the buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pair_valid | input | 1 | One-cycle strobe: a new I/Q pair is present |
| i_sample | input | 15 | I sample, two's complement |
| q_sample | input | 15 | Q sample, two's complement |
| rate_fast | input | 1 | 1: serial clock is master/2; 0: serial clock is master/4 |
| rx_active | input | 1 | Request to stream; 0 requests sleep after the current pair |
| out_release | input | 1 | 1 releases the serial pins to high impedance |
| ser_clk | output | 1 | Serial bit clock |
| ser_frame | output | 1 | Frame marker |
| ser_data | output | 1 | Serial data |
| ser_oe | output | 1 | Pad drive enable for ser_clk, ser_frame and ser_data |
| overrun | output | 1 | Sticky flag: a pair was dropped |

## Verification
The assertions assume that `pair_valid` is a synchronous strobe and that reset is held for at least one clock edge. They place no limits on when `rx_active` or `rate_fast` may change, because the design samples these only at defined points. The stimulus changes every input on the falling master clock edge. It sends single-cycle pair strobes, both while asleep and in the middle of a word. It drops `rx_active` at a range of points inside a pair, so the rule that a started pair is completed is exercised by the stimulus itself and not by careful timing in the bench.

// File: rtl/iq_framer_pkg.sv
package iq_framer_pkg;
   typedef enum logic [1:0] {
      FS_SLEEP = 2'd0,
      FS_LEAD  = 2'd1,
      FS_WORD  = 2'd2
   } frm_state_t;
endpackage

// File: rtl/iq_pair_buffer.sv
module iq_pair_buffer #(
   parameter int SAMPLE_W = 15
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   input  logic [SAMPLE_W-1:0] in_i,
   input  logic [SAMPLE_W-1:0] in_q,
   input  logic                take,
   output logic                full,
   output logic [SAMPLE_W-1:0] out_i,
   output logic [SAMPLE_W-1:0] out_q,
   output logic                overrun
);
   logic accept;

   // a slot frees up in the same cycle it is consumed
   assign accept = in_valid && (!full || take);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full    <= 1'b0;
         out_i   <= '0;
         out_q   <= '0;
         overrun <= 1'b0;
      end else begin
         if (take)
            full <= in_valid;
         else if (in_valid)
            full <= 1'b1;
         if (accept) begin
            out_i <= in_i;
            out_q <= in_q;
         end
         if (in_valid && full && !take)
            overrun <= 1'b1;
      end
   end
endmodule

// File: rtl/iq_bit_timer.sv
module iq_bit_timer #(
   parameter int FAST_DIV = 2,
   parameter int SLOW_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic rate_fast,
   output logic bit_end,
   output logic sclk
);
   localparam int DIV_W = $clog2(SLOW_DIV + 1);

   logic [DIV_W-1:0] ph;
   logic [DIV_W-1:0] div;

   generate
      if (FAST_DIV == SLOW_DIV) begin : g_single
         logic unused_rate;
         assign unused_rate = rate_fast;
         assign div = DIV_W'(SLOW_DIV);
      end else begin : g_dual
         logic fast_q;
         // rate follows the input while idle and freezes once running
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               fast_q <= 1'b0;
            else if (!run)
               fast_q <= rate_fast;
         end
         assign div = fast_q ? DIV_W'(FAST_DIV) : DIV_W'(SLOW_DIV);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ph <= '0;
      else if (!run || ph == div - 1'b1)
         ph <= '0;
      else
         ph <= ph + 1'b1;
   end

   assign bit_end = run && (ph == div - 1'b1);
   assign sclk    = run && (ph < (div >> 1));
endmodule

// File: rtl/iq_word_shifter.sv
module iq_word_shifter #(
   parameter int SAMPLE_W = 15
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load_pair,
   input  logic [SAMPLE_W-1:0] pair_i,
   input  logic [SAMPLE_W-1:0] pair_q,
   input  logic                load_q,
   input  logic                next_bit,
   input  logic                clear,
   output logic                msb
);
   localparam int WORD_W = SAMPLE_W + 1;

   logic [WORD_W-1:0]   sh;
   logic [SAMPLE_W-1:0] q_hold;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh     <= '0;
         q_hold <= '0;
      end else if (clear) begin
         sh     <= '0;
      end else if (load_pair) begin
         sh     <= {pair_i, 1'b1};
         q_hold <= pair_q;
      end else if (load_q) begin
         sh     <= {q_hold, 1'b0};
      end else if (next_bit) begin
         sh     <= {sh[WORD_W-2:0], 1'b0};
      end
   end

   assign msb = sh[WORD_W-1];
endmodule

// File: rtl/iq_serial_framer.sv
module iq_serial_framer
   import iq_framer_pkg::*;
#(
   parameter int SAMPLE_W = 15,
   parameter int FAST_DIV = 2,
   parameter int SLOW_DIV = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                pair_valid,
   input  logic [SAMPLE_W-1:0] i_sample,
   input  logic [SAMPLE_W-1:0] q_sample,
   input  logic                rate_fast,
   input  logic                rx_active,
   input  logic                out_release,
   output logic                ser_clk,
   output logic                ser_frame,
   output logic                ser_data,
   output logic                ser_oe,
   output logic                overrun
);
   localparam int WORD_W = SAMPLE_W + 1;
   localparam int BIT_W  = $clog2(WORD_W);
   localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);

   generate
      if (SAMPLE_W < 2) begin : g_bad_width
         $error("SAMPLE_W must be at least 2");
      end
      if (FAST_DIV < 2 || (FAST_DIV % 2) != 0) begin : g_bad_fast
         $error("FAST_DIV must be even and at least 2");
      end
      if (SLOW_DIV < FAST_DIV || (SLOW_DIV % 2) != 0) begin : g_bad_slow
         $error("SLOW_DIV must be even and not below FAST_DIV");
      end
   endgenerate

   frm_state_t       state;
   logic [BIT_W-1:0] bit_idx;
   logic             in_q;
   logic             running;
   logic             bit_end;
   logic             at_last;
   logic             pend_full;
   logic             pend_take;
   logic [SAMPLE_W-1:0] pend_i, pend_q;
   logic             load_q, next_bit, sh_clear, sh_msb;
   logic             pair_end;

   assign running  = (state != FS_SLEEP);
   assign at_last  = (bit_idx == LAST_BIT);
   assign pair_end = bit_end && (state == FS_WORD) && at_last && in_q;
   assign pend_take = (bit_end && state == FS_LEAD) || (pair_end && rx_active);
   assign load_q   = bit_end && (state == FS_WORD) && at_last && !in_q;
   assign next_bit = bit_end && (state == FS_WORD) && !at_last;
   assign sh_clear = pair_end && !rx_active;

   iq_pair_buffer #(.SAMPLE_W(SAMPLE_W)) u_buf (
      .clk     (clk),
      .rst_n   (rst_n),
      .in_valid(pair_valid),
      .in_i    (i_sample),
      .in_q    (q_sample),
      .take    (pend_take),
      .full    (pend_full),
      .out_i   (pend_i),
      .out_q   (pend_q),
      .overrun (overrun)
   );

   iq_bit_timer #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (running),
      .rate_fast(rate_fast),
      .bit_end  (bit_end),
      .sclk     (ser_clk)
   );

   iq_word_shifter #(.SAMPLE_W(SAMPLE_W)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_pair(pend_take),
      .pair_i   (pend_full ? pend_i : '0),
      .pair_q   (pend_full ? pend_q : '0),
      .load_q   (load_q),
      .next_bit (next_bit),
      .clear    (sh_clear),
      .msb      (sh_msb)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= FS_SLEEP;
         bit_idx <= '0;
         in_q    <= 1'b0;
      end else begin
         unique case (state)
            FS_SLEEP: if (rx_active) state <= FS_LEAD;
            FS_LEAD: if (bit_end) begin
               state   <= FS_WORD;
               bit_idx <= '0;
               in_q    <= 1'b0;
            end
            FS_WORD: if (bit_end) begin
               if (!at_last) begin
                  bit_idx <= bit_idx + 1'b1;
               end else if (!in_q) begin
                  in_q    <= 1'b1;
                  bit_idx <= '0;
               end else if (rx_active) begin
                  in_q    <= 1'b0;
                  bit_idx <= '0;
               end else begin
                  state   <= FS_SLEEP;
                  in_q    <= 1'b0;
                  bit_idx <= '0;
               end
            end
            default: state <= FS_SLEEP;
         endcase
      end
   end

   assign ser_frame = (state == FS_LEAD) || (state == FS_WORD && at_last);
   assign ser_data  = (state == FS_WORD) && sh_msb;
   assign ser_oe    = !out_release;
endmodule

// File: rtl/iq_framer_checker.sv
module iq_framer_checker (
   input logic clk,
   input logic rst_n,
   input logic pair_valid,
   input logic buf_full,
   input logic buf_take,
   input logic overrun,
   input logic running,
   input logic q_word,
   input logic last_bit,
   input logic ser_clk,
   input logic ser_frame,
   input logic ser_data
);
   // R8: idle serial pins
   a_r8_sleep_low: assert property (@(posedge clk) disable iff (!rst_n)
      !running |-> (!ser_clk && !ser_frame && !ser_data));

   // R12: dropped pair sets the flag
   a_r12_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
      (pair_valid && buf_full && !buf_take) |=> overrun);

   // R12: flag is sticky
   a_r12_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |=> overrun);

   // R5: data and frame move only with a rising serial clock
   a_r5_stable_between_rises: assert property (@(posedge clk) disable iff (!rst_n)
      (running && $past(running) && !$rose(ser_clk)) |->
         ($stable(ser_data) && $stable(ser_frame)));

   // R7: sleep is entered only after a Q word's last bit
   a_r7_pair_completes: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(running) |-> ($past(q_word) && $past(last_bit)));
endmodule

bind iq_serial_framer iq_framer_checker u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .pair_valid(pair_valid),
   .buf_full  (pend_full),
   .buf_take  (pend_take),
   .overrun   (overrun),
   .running   (running),
   .q_word    (in_q),
   .last_bit  (at_last),
   .ser_clk   (ser_clk),
   .ser_frame (ser_frame),
   .ser_data  (ser_data)
);

// File: tb/test_iq_serial_framer.sv
module test_iq_serial_framer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pair_valid = 1'b0;
   logic [14:0] i_sample = '0;
   logic [14:0] q_sample = '0;
   logic        rate_fast = 1'b1;
   logic        rx_active = 1'b0;
   logic        out_release = 1'b0;
   logic        ser_clk, ser_frame, ser_data, ser_oe, overrun;

   int checks = 0;
   int errors = 0;

   logic cap_f [0:255];
   logic cap_d [0:255];
   int   ncap = 0;
   int   cyc = 0;
   int   last_rise = 0;
   int   last_gap = 0;
   logic prev_sclk = 1'b0;

   always #2 clk = ~clk;

   iq_serial_framer i_iq_serial_framer (
      .clk(clk), .rst_n(rst_n), .pair_valid(pair_valid),
      .i_sample(i_sample), .q_sample(q_sample), .rate_fast(rate_fast),
      .rx_active(rx_active), .out_release(out_release),
      .ser_clk(ser_clk), .ser_frame(ser_frame), .ser_data(ser_data),
      .ser_oe(ser_oe), .overrun(overrun)
   );

   // capture frame/data at every falling serial clock, time the rises
   always @(negedge clk) begin
      cyc = cyc + 1;
      if (prev_sclk && !ser_clk && ncap < 256) begin
         cap_f[ncap] = ser_frame;
         cap_d[ncap] = ser_data;
         ncap = ncap + 1;
      end
      if (!prev_sclk && ser_clk) begin
         last_gap  = cyc - last_rise;
         last_rise = cyc;
      end
      prev_sclk = ser_clk;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [15:0] data_word(input int base);
      logic [15:0] w = '0;
      for (int k = 0; k < 16; k++) w = {w[14:0], cap_d[base + k]};
      return w;
   endfunction

   function automatic logic [15:0] frame_word(input int base);
      logic [15:0] w = '0;
      for (int k = 0; k < 16; k++) w = {w[14:0], cap_f[base + k]};
      return w;
   endfunction

   task automatic send_pair(input logic [14:0] iv, input logic [14:0] qv);
      @(negedge clk);
      i_sample = iv; q_sample = qv; pair_valid = 1'b1;
      @(negedge clk);
      pair_valid = 1'b0;
   endtask

   task automatic wait_clks(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   task automatic check_pair(input int base, input logic [14:0] iv,
                             input logic [14:0] qv, input string req);
      chk(data_word(base) == {iv, 1'b1}, req, "I word", data_word(base), {iv, 1'b1});
      chk(data_word(base + 16) == {qv, 1'b0}, req, "Q word", data_word(base + 16), {qv, 1'b0});
      chk(frame_word(base) == 16'h0001, "R6", "frame in I word", frame_word(base), 16'h0001);
      chk(frame_word(base + 16) == 16'h0001, "R6", "frame in Q word", frame_word(base + 16), 16'h0001);
   endtask

   task automatic check_idle(input string req);
      chk({ser_clk, ser_frame, ser_data} == 3'b000, req, "idle pins",
          {ser_clk, ser_frame, ser_data}, 3'b000);
   endtask

   task automatic t_reset;
      check_idle("R13");
      chk(overrun == 1'b0, "R13", "overrun after reset", overrun, 0);
      chk(ser_oe == 1'b1, "R9", "oe driven", ser_oe, 1);
   endtask

   task automatic t_single_fast;
      rate_fast = 1'b1;
      send_pair(15'h5A3C, 15'h2B71);
      ncap = 0;
      @(negedge clk); rx_active = 1'b1;
      wait_clks(3);
      rx_active = 1'b0;           // R7: request sleep inside the lead/I word
      wait_clks(150);
      chk(ncap == 33, "R7", "bits in one pair", ncap, 33);
      chk(cap_f[0] == 1'b1 && cap_d[0] == 1'b0, "R6", "lead bit", {cap_f[0], cap_d[0]}, 2'b10);
      check_pair(1, 15'h5A3C, 15'h2B71, "R1 R2");
      chk(last_gap == 2, "R3", "fast period", last_gap, 2);
      check_idle("R8");
   endtask

   task automatic t_stream_slow;
      rate_fast = 1'b0;
      send_pair(15'h7001, 15'h0ACE);
      ncap = 0;
      @(negedge clk); rx_active = 1'b1;
      while (ncap < 5) @(negedge clk);
      send_pair(15'h1357, 15'h6420);   // R10: arrives mid-word
      while (ncap < 10) @(negedge clk);
      rate_fast = 1'b1;                // R4: must be ignored while running
      while (ncap < 34) @(negedge clk);
      rx_active = 1'b0;
      wait_clks(300);
      chk(ncap == 65, "R2", "bits in two pairs", ncap, 65);
      check_pair(1, 15'h7001, 15'h0ACE, "R1");
      check_pair(33, 15'h1357, 15'h6420, "R10");
      chk(last_gap == 4, "R4", "slow period kept", last_gap, 4);
      check_idle("R8");
      chk(overrun == 1'b0, "R12", "no overrun", overrun, 0);
   endtask

   task automatic t_underflow;
      rate_fast = 1'b1;
      ncap = 0;
      @(negedge clk); rx_active = 1'b1;
      wait_clks(20);
      rx_active = 1'b0;
      wait_clks(150);
      chk(ncap == 33, "R11", "bits", ncap, 33);
      chk(data_word(1) == 16'h0001, "R11", "empty I word", data_word(1), 16'h0001);
      chk(data_word(17) == 16'h0000, "R11", "empty Q word", data_word(17), 16'h0000);
      chk(last_gap == 2, "R3", "fast period after wake", last_gap, 2);
   endtask

   task automatic t_overrun;
      send_pair(15'h0F0F, 15'h3C3C);
      chk(overrun == 1'b0, "R12", "single pair no overrun", overrun, 0);
      send_pair(15'h7FFF, 15'h7FFF);
      chk(overrun == 1'b1, "R12", "second pair overruns", overrun, 1);
      ncap = 0;
      @(negedge clk); rx_active = 1'b1;
      wait_clks(2);
      rx_active = 1'b0;
      wait_clks(150);
      check_pair(1, 15'h0F0F, 15'h3C3C, "R12");
      chk(overrun == 1'b1, "R12", "overrun sticky", overrun, 1);
   endtask

   task automatic t_release;
      @(negedge clk); out_release = 1'b1;
      #0;
      chk(ser_oe == 1'b0, "R9", "oe released", ser_oe, 0);
      send_pair(15'h2468, 15'h1111);
      ncap = 0;
      @(negedge clk); rx_active = 1'b1;
      wait_clks(2);
      rx_active = 1'b0;
      wait_clks(150);
      chk(ncap == 33, "R9", "stream while released", ncap, 33);
      check_pair(1, 15'h2468, 15'h1111, "R9");
      @(negedge clk); out_release = 1'b0;
      #0;
      chk(ser_oe == 1'b1, "R9", "oe driven again", ser_oe, 1);
   endtask

   task automatic finish_run;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      #(4 * 150000);
      checks++;
      errors++;
      $display("FAIL watchdog run did not complete");
      finish_run();
   end

   initial begin
      wait_clks(3);
      rst_n = 1'b1;
      wait_clks(2);
      t_reset();
      t_single_fast();
      t_stream_slow();
      t_underflow();
      t_overrun();
      t_release();
      finish_run();
   end
endmodule